// File: doc/BRIEF.md
# Multiprocessor Spin-Table Release Unit

This block holds one boot-release record per processor of a multicore system, in a flat register space reached through a simple valid/ready register port. Secondary cores stay parked until their record is armed. A bus master fills in a record with 8-, 16- or 32-bit big-endian accesses and can read every record back. After each accepted write, the block looks at the record's 64-bit start address. If that address is even, it releases the matching core.

A release is a one-cycle pulse on the per-core `rel_valid` bit. In the same cycle the block presents the payload registers. The start program counter is the start address masked to the low bits of a 64 MiB initial window. The window base is the start address with those low bits cleared. The argument value and the window size complete the payload. At the same time, the record's processor-number word is overwritten with the hardware identity of the core being released.

Each record is 32 bytes and the space holds 32 of them. A record is laid out by big-endian word slot:

| Word slot | Content |
|---|---|
| 0 | start address, high half |
| 1 | start address, low half (bit 0 is the spin flag) |
| 2 | argument, high half |
| 3 | argument, low half |
| 4 | spare |
| 5 | processor number |
| 6 | spare |
| 7 | spare |

Record 0 belongs to the boot core, so writes to it have no effect. Writes to records at or above the configured core count also have no effect.

Top module: `spin_release_unit`

## Requirements
- R1: After reset, record i holds start address 1 (word slot 1 = 1, slot 0 = 0), argument i (slot 3 = i, slot 2 = 0) and processor number i (slot 5). All other slots hold 0.
- R2: A read returns its bytes right-aligned in `rsp_rdata`, in the cycle after acceptance, with `rsp_err` low. Byte offset 0 of a word is its most significant byte. Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes.
- R3: A 1- or 2-byte write changes only the addressed bytes of its word, using the same big-endian byte numbering. A 4-byte write replaces the whole word.
- R4: Writes to record 0, or to a record whose index is at least NUM_CORES, are answered without error. They leave the record unchanged and cause no release.
- R5: Size code 3, a 2-byte access at an odd address, a 4-byte access at an address that is not a multiple of 4, and any address of 1024 or above are all answered with `rsp_err` high and `rsp_rdata` zero. They change no state and cause no release.
- R6: In the cycle after an accepted write to a writable record, `rel_valid` raises exactly the bit of that record's core for one cycle, if bit 0 of the record's updated start address is 0.
- R7: With the pulse, `rel_pc` is the start address ANDed with 2^26 − 1, `rel_base` is the start address with bits 25:0 cleared, `rel_arg` is the record's 64-bit argument, and `rel_win_size` is 2^26.
- R8: Every later accepted write to a record whose start address is still even releases that core again, whatever slot the write hit.
- R9: On release, slot 5 of the record becomes the core's hardware identity taken from `core_hwid`. This value wins over any data the same write placed there.
- R10: `req_ready` is always high. Every request gets exactly one response, with `rsp_valid` high in the following cycle. Back-to-back requests are served at one per cycle.
- R11: A write that leaves bit 0 of the start address at 1, such as writing the high half first, produces no release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 = byte, 1 = halfword, 2 = word, 3 = invalid |
| req_wdata | input | 32 | Write value, right-aligned |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 32 | Read value, right-aligned |
| core_hwid | input | NUM_CORES*32 | Hardware identity of each core, core i in bits 32i+31:32i |
| rel_valid | output | NUM_CORES | One-cycle release pulse per core |
| rel_pc | output | 64 | Start program counter inside the window |
| rel_arg | output | 64 | Argument handed to the released core |
| rel_base | output | 64 | Base of the initial memory window |
| rel_win_size | output | 64 | Size of the initial memory window |

## Verification
The bench splits a start address across two word writes, high half first. A design that checked the flag before merging the write would release too early or never. It also writes to the boot record and to a record just past the core count. A design that gated these wrongly would pulse `rel_valid[0]` or change memory that reads back unchanged. Misaligned and oversized accesses are followed by readbacks, to catch a design that flags the error but still writes. Repeated writes to an armed record, including one to a spare slot, check that each write releases again and that the processor-number word ends up holding the hardware identity, not the written value.

// File: rtl/spin_pkg.sv
package spin_pkg;

    localparam int ENTRY_BYTES = 32;
    localparam int ENTRY_WORDS = ENTRY_BYTES / 4;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
    localparam int WORD_IDX_W  = $clog2(ENTRY_WORDS);

    // Word slots inside one record; the release logic decodes these.
    localparam logic [WORD_IDX_W-1:0] SLOT_START_HI = 3'd0;
    localparam logic [WORD_IDX_W-1:0] SLOT_START_LO = 3'd1;
    localparam logic [WORD_IDX_W-1:0] SLOT_ARG_HI   = 3'd2;
    localparam logic [WORD_IDX_W-1:0] SLOT_ARG_LO   = 3'd3;
    localparam logic [WORD_IDX_W-1:0] SLOT_PROC_NUM = 3'd5;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [3:0]  be;    // lane 3 = bits 31:24 = byte offset 0
        logic [31:0] data;
    } lane_wr_t;

    function automatic logic [3:0] lane_mask(acc_size_e sz, logic [1:0] boff);
        case (sz)
            SZ_BYTE: return 4'b1000 >> boff;
            SZ_HALF: return boff[1] ? 4'b0011 : 4'b1100;
            SZ_WORD: return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] place_wdata(acc_size_e sz, logic [1:0] boff,
                                                logic [31:0] d);
        logic [1:0] sh;
        sh = 2'd3 - boff;
        case (sz)
            SZ_BYTE: return {24'd0, d[7:0]} << {sh, 3'b000};
            SZ_HALF: return boff[1] ? {16'd0, d[15:0]} : {d[15:0], 16'd0};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] extract_rdata(acc_size_e sz, logic [1:0] boff,
                                                  logic [31:0] w);
        logic [1:0] sh;
        sh = 2'd3 - boff;
        case (sz)
            SZ_BYTE: return (w >> {sh, 3'b000}) & 32'h0000_00FF;
            SZ_HALF: return boff[1] ? {16'd0, w[15:0]} : {16'd0, w[31:16]};
            SZ_WORD: return w;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] merge_lanes(logic [31:0] old, lane_wr_t wr);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) begin
            r[8*i +: 8] = wr.be[i] ? wr.data[8*i +: 8] : old[8*i +: 8];
        end
        return r;
    endfunction

    function automatic logic [31:0] reset_word(int entry, int slot);
        if (slot == int'(SLOT_START_LO)) return 32'd1;
        if (slot == int'(SLOT_ARG_LO))   return 32'(entry);
        if (slot == int'(SLOT_PROC_NUM)) return 32'(entry);
        return 32'd0;
    endfunction

endpackage

// File: rtl/spin_bus_decode.sv
module spin_bus_decode
    import spin_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int NUM_CORES   = 4,
    parameter int ADDR_W      = 16,
    parameter int EIDX_W      = 5
) (
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [1:0]            req_size,
    input  logic [31:0]           req_wdata,
    output logic                  acc_err,
    output logic                  wr_en,
    output logic [EIDX_W-1:0]     entry,
    output logic [WORD_IDX_W-1:0] word,
    output logic [1:0]            boff,
    output acc_size_e             size,
    output lane_wr_t              lane
);

    localparam int SPACE_BYTES = NUM_ENTRIES * ENTRY_BYTES;

    logic in_range;
    logic misaligned;
    logic core_ok;

    always_comb begin
        size       = acc_size_e'(req_size);
        entry      = req_addr[ENTRY_SHIFT +: EIDX_W];
        word       = req_addr[2 +: WORD_IDX_W];
        boff       = req_addr[1:0];
        in_range   = 32'(req_addr) < SPACE_BYTES;
        misaligned = (size == SZ_HALF && req_addr[0]) ||
                     (size == SZ_WORD && req_addr[1:0] != 2'b00);
        acc_err    = req_valid && (!in_range || misaligned || size == SZ_BAD);
        core_ok    = (entry != '0) && (32'(entry) < NUM_CORES);
        wr_en      = req_valid && req_write && !acc_err && core_ok;
        lane.be    = lane_mask(size, boff);
        lane.data  = place_wdata(size, boff, req_wdata);
    end

endmodule

// File: rtl/spin_entry_store.sv
module spin_entry_store
    import spin_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int EIDX_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [EIDX_W-1:0]     wr_entry,
    input  logic [WORD_IDX_W-1:0] wr_word,
    input  lane_wr_t              wr_lane,
    input  logic                  rel_fire,
    input  logic [31:0]           rel_hwid,
    input  logic [EIDX_W-1:0]     rd_entry,
    input  logic [WORD_IDX_W-1:0] rd_word,
    output logic [31:0]           rd_data,
    output logic [63:0]           nxt_start,
    output logic [63:0]           nxt_arg
);

    logic [31:0] mem [NUM_ENTRIES][ENTRY_WORDS];
    logic [31:0] nxt_w [4];

    // View of the written record's first four slots after this write lands.
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            if (wr_en && wr_word == WORD_IDX_W'(k))
                nxt_w[k] = merge_lanes(mem[wr_entry][k], wr_lane);
            else
                nxt_w[k] = mem[wr_entry][k];
        end
        nxt_start = {nxt_w[SLOT_START_HI], nxt_w[SLOT_START_LO]};
        nxt_arg   = {nxt_w[SLOT_ARG_HI],   nxt_w[SLOT_ARG_LO]};
        rd_data   = mem[rd_entry][rd_word];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                for (int w = 0; w < ENTRY_WORDS; w++) begin
                    mem[e][w] <= reset_word(e, w);
                end
            end
        end else begin
            if (wr_en) begin
                mem[wr_entry][wr_word] <= merge_lanes(mem[wr_entry][wr_word], wr_lane);
            end
            // Identity overwrite is issued last so it wins over the bus data.
            if (rel_fire) begin
                mem[wr_entry][SLOT_PROC_NUM] <= rel_hwid;
            end
        end
    end

    // R9
    fire_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        rel_fire |-> wr_en);

endmodule

// File: rtl/spin_release_gen.sv
module spin_release_gen
    import spin_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int EIDX_W    = 5,
    parameter int WIN_LOG2  = 26
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [EIDX_W-1:0]    wr_entry,
    input  logic [63:0]          nxt_start,
    input  logic [63:0]          nxt_arg,
    output logic                 fire,
    output logic [NUM_CORES-1:0] rel_valid,
    output logic [63:0]          rel_pc,
    output logic [63:0]          rel_arg,
    output logic [63:0]          rel_base,
    output logic [63:0]          rel_win_size
);

    localparam logic [63:0] WIN_BYTES = 64'd1 << WIN_LOG2;
    localparam logic [63:0] WIN_MASK  = WIN_BYTES - 64'd1;

    assign fire = wr_en && !nxt_start[0];

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_pulse
        always_ff @(posedge clk) begin
            if (rst) rel_valid[c] <= 1'b0;
            else     rel_valid[c] <= fire && (wr_entry == EIDX_W'(c));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rel_pc       <= '0;
            rel_arg      <= '0;
            rel_base     <= '0;
            rel_win_size <= '0;
        end else if (fire) begin
            rel_pc       <= nxt_start & WIN_MASK;
            rel_base     <= nxt_start & ~WIN_MASK;
            rel_arg      <= nxt_arg;
            rel_win_size <= WIN_BYTES;
        end
    end

    // R6
    rel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rel_valid));

    // R4
    boot_core_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rel_valid[0]);

    // R7
    window_split_chk: assert property (@(posedge clk) disable iff (rst)
        (|rel_valid) |-> ((rel_pc & rel_base) == 64'd0 && rel_pc < rel_win_size
                          && rel_win_size == WIN_BYTES));

endmodule

// File: rtl/spin_release_unit.sv
module spin_release_unit
    import spin_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int NUM_CORES   = 4,
    parameter int ADDR_W      = 16,
    parameter int WIN_LOG2    = 26
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [1:0]             req_size,
    input  logic [31:0]            req_wdata,
    output logic                   rsp_valid,
    output logic                   rsp_err,
    output logic [31:0]            rsp_rdata,
    input  logic [NUM_CORES*32-1:0] core_hwid,
    output logic [NUM_CORES-1:0]   rel_valid,
    output logic [63:0]            rel_pc,
    output logic [63:0]            rel_arg,
    output logic [63:0]            rel_base,
    output logic [63:0]            rel_win_size
);

    localparam int EIDX_W = $clog2(NUM_ENTRIES);

    logic                  acc_err;
    logic                  wr_en;
    logic [EIDX_W-1:0]     entry;
    logic [WORD_IDX_W-1:0] word;
    logic [1:0]            boff;
    acc_size_e             size;
    lane_wr_t              lane;
    logic                  fire;
    logic [31:0]           hwid_sel;
    logic [31:0]           rd_word_data;
    logic [63:0]           nxt_start;
    logic [63:0]           nxt_arg;

    assign req_ready = 1'b1;

    spin_bus_decode #(
        .NUM_ENTRIES(NUM_ENTRIES), .NUM_CORES(NUM_CORES),
        .ADDR_W(ADDR_W), .EIDX_W(EIDX_W)
    ) u_decode (
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .acc_err(acc_err), .wr_en(wr_en), .entry(entry), .word(word),
        .boff(boff), .size(size), .lane(lane)
    );

    always_comb begin
        hwid_sel = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (entry == EIDX_W'(c)) hwid_sel = core_hwid[32*c +: 32];
        end
    end

    spin_entry_store #(
        .NUM_ENTRIES(NUM_ENTRIES), .EIDX_W(EIDX_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_entry(entry), .wr_word(word), .wr_lane(lane),
        .rel_fire(fire), .rel_hwid(hwid_sel),
        .rd_entry(entry), .rd_word(word), .rd_data(rd_word_data),
        .nxt_start(nxt_start), .nxt_arg(nxt_arg)
    );

    spin_release_gen #(
        .NUM_CORES(NUM_CORES), .EIDX_W(EIDX_W), .WIN_LOG2(WIN_LOG2)
    ) u_release (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_entry(entry),
        .nxt_start(nxt_start), .nxt_arg(nxt_arg),
        .fire(fire), .rel_valid(rel_valid),
        .rel_pc(rel_pc), .rel_arg(rel_arg), .rel_base(rel_base),
        .rel_win_size(rel_win_size)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= acc_err;
            rsp_rdata <= (req_valid && !req_write && !acc_err)
                         ? extract_rdata(size, boff, rd_word_data) : 32'd0;
        end
    end

    // R10
    rsp_has_req_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));

    // R10
    req_gets_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R5
    err_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == 32'd0));

    // R6
    rel_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (|rel_valid) |-> $past(req_valid && req_write));

endmodule

// File: tb/tb_spin_release_unit.sv
module tb_spin_release_unit;

    localparam int NE = 32;
    localparam int NC = 4;
    localparam logic [63:0] WIN = 64'h0000_0000_0400_0000;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 req_valid;
    logic                 req_ready;
    logic                 req_write;
    logic [15:0]          req_addr;
    logic [1:0]           req_size;
    logic [31:0]          req_wdata;
    logic                 rsp_valid;
    logic                 rsp_err;
    logic [31:0]          rsp_rdata;
    logic [NC*32-1:0]     core_hwid;
    logic [NC-1:0]        rel_valid;
    logic [63:0]          rel_pc, rel_arg, rel_base, rel_win_size;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        string       tag;
    } rsp_exp_t;

    typedef struct {
        int          core;
        logic [63:0] pc;
        logic [63:0] arg;
        logic [63:0] base;
        string       tag;
    } rel_exp_t;

    rsp_exp_t rsp_q[$];
    rel_exp_t rel_q[$];
    logic [7:0] mdl [NE][32];

    always #5 clk = ~clk;

    spin_release_unit #(.NUM_ENTRIES(NE), .NUM_CORES(NC)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .core_hwid(core_hwid), .rel_valid(rel_valid),
        .rel_pc(rel_pc), .rel_arg(rel_arg), .rel_base(rel_base),
        .rel_win_size(rel_win_size)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] hwid_of(int c);
        return 32'h0000_0100 + 32'(c);
    endfunction

    // Driver: presents one request per call and queues what must come back.
    task automatic access(input bit wr, input int addr, input int sz,
                          input logic [31:0] wd, input string tag);
        rsp_exp_t ex;
        rel_exp_t rx;
        int n, e, o;
        bit err;
        logic [63:0] start, arg;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = 16'(addr);
        req_size  = 2'(sz);
        req_wdata = wd;
        n   = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
        err = (sz == 3) || (addr >= NE*32) || (sz == 1 && addr % 2 != 0) ||
              (sz == 2 && addr % 4 != 0);
        e = addr / 32;
        o = addr % 32;
        ex.err = err;
        ex.rdata = 32'd0;
        ex.tag = tag;
        if (!err && !wr) begin
            for (int k = 0; k < n; k++) ex.rdata = (ex.rdata << 8) | 32'(mdl[e][o+k]);
        end
        rsp_q.push_back(ex);
        if (!err && wr && e >= 1 && e < NC) begin
            for (int k = 0; k < n; k++) mdl[e][o+k] = wd[8*(n-1-k) +: 8];
            start = '0;
            arg = '0;
            for (int k = 0; k < 8; k++) begin
                start = (start << 8) | 64'(mdl[e][k]);
                arg   = (arg << 8)   | 64'(mdl[e][8+k]);
            end
            if (!start[0]) begin
                rx.core = e;
                rx.pc   = start & (WIN - 64'd1);
                rx.base = start & ~(WIN - 64'd1);
                rx.arg  = arg;
                rx.tag  = tag;
                rel_q.push_back(rx);
                for (int k = 0; k < 4; k++) mdl[e][20+k] = hwid_of(e)[8*(3-k) +: 8];
            end
        end
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: compares every response and release against the queues.
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                if (rsp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected response", 64'(rsp_rdata), 64'd0);
                end else begin
                    rsp_exp_t ex;
                    ex = rsp_q.pop_front();
                    chk(rsp_rdata == ex.rdata && rsp_err == ex.err, ex.tag,
                        {31'd0, rsp_err, rsp_rdata}, {31'd0, ex.err, ex.rdata});
                end
            end
            if (|rel_valid) begin
                if (rel_q.size() == 0) begin
                    chk(1'b0, "R4 R11 unexpected release", 64'(rel_valid), 64'd0);
                end else begin
                    rel_exp_t rx;
                    rx = rel_q.pop_front();
                    chk(rel_valid == NC'(1 << rx.core), {rx.tag, " R6 pulse"},
                        64'(rel_valid), 64'(1 << rx.core));
                    chk(rel_pc == rx.pc && rel_base == rx.base, {rx.tag, " R7 pc/base"},
                        rel_pc ^ rel_base, rx.pc ^ rx.base);
                    chk(rel_arg == rx.arg, {rx.tag, " R7 arg"}, rel_arg, rx.arg);
                    chk(rel_win_size == WIN, {rx.tag, " R7 size"}, rel_win_size, WIN);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) core_hwid[32*c +: 32] = hwid_of(c);
        for (int e = 0; e < NE; e++) begin
            for (int b = 0; b < 32; b++) mdl[e][b] = 8'h00;
            mdl[e][7]  = 8'h01;
            mdl[e][15] = 8'(e);
            mdl[e][23] = 8'(e);
        end
        rst = 1'b1;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr = '0;
        req_size = '0;
        req_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b0 && rel_valid == '0, "R10 reset quiet",
            {63'd0, rsp_valid}, 64'd0);

        // R1 reset contents
        for (int e = 0; e < 6; e++) begin
            access(0, e*32 + 0,  2, 0, "R1 start hi");
            access(0, e*32 + 4,  2, 0, "R1 start lo");
            access(0, e*32 + 12, 2, 0, "R1 arg lo");
            access(0, e*32 + 20, 2, 0, "R1 proc num");
        end
        access(0, 31*32 + 20, 2, 0, "R1 last record");

        // R2 narrow reads, big-endian numbering
        access(0, 3*32 + 23, 0, 0, "R2 byte lsb");
        access(0, 3*32 + 20, 0, 0, "R2 byte msb");
        access(0, 3*32 + 22, 1, 0, "R2 half low");
        access(0, 3*32 + 20, 1, 0, "R2 half high");

        // R5 rejected accesses
        access(0, 0, 3, 0, "R5 bad size read");
        access(0, 1024, 2, 0, "R5 out of range read");
        access(1, 32 + 6, 2, 32'h0, "R5 misaligned word write");
        access(1, 32 + 5, 1, 32'h0, "R5 odd half write");
        access(1, 32 + 4, 3, 32'h0, "R5 bad size write");
        access(1, 1024 + 36, 2, 32'h0, "R5 out of range write");
        access(0, 32 + 4, 2, 0, "R5 no side effect");

        // R4 dropped writes
        access(1, 4, 2, 32'h0, "R4 boot record write");
        access(0, 4, 2, 0, "R4 boot record unchanged");
        access(1, NC*32 + 4, 2, 32'h0, "R4 beyond core count write");
        access(0, NC*32 + 4, 2, 0, "R4 beyond core count unchanged");
        access(1, 31*32 + 4, 2, 32'h0, "R4 last record write");
        access(0, 31*32 + 4, 2, 0, "R4 last record unchanged");

        // R11 high half first keeps spinning, then R6 R7 release
        access(1, 32 + 0, 2, 32'h0000_0001, "R11 high half only");
        access(0, 32 + 0, 2, 0, "R11 high half readback");
        access(1, 32 + 4, 2, 32'h0500_1000, "R6 R7 low half arms core 1");
        access(0, 32 + 20, 2, 0, "R9 identity after release");

        // R8 re-release on argument write
        access(1, 32 + 12, 2, 32'h0000_CAFE, "R8 argument rewrite");
        access(1, 32 + 20, 2, 32'hDEAD_BEEF, "R9 write to proc num");
        access(0, 32 + 20, 2, 0, "R9 identity wins");

        // R3 narrow writes on record 2
        access(1, 64 + 8, 0, 32'h0000_00AB, "R3 byte into arg msb");
        access(0, 64 + 8, 2, 0, "R3 byte merge readback");
        access(1, 64 + 6, 1, 32'h0000_2000, "R3 half clears spin flag");
        access(0, 64 + 4, 2, 0, "R3 half merge readback");

        // Record 3: byte release, then back-to-back word writes
        access(1, 96 + 7, 0, 32'h0000_0040, "R3 R6 byte release");
        access(1, 96 + 0, 2, 32'hFFFF_FFFF, "R8 back-to-back hi");
        access(1, 96 + 4, 2, 32'hFFFF_FFFC, "R8 back-to-back lo");
        access(1, 96 + 16, 2, 32'h1234_5678, "R8 spare slot write");
        access(0, 96 + 16, 2, 0, "R3 spare slot readback");
        access(1, 96 + 4, 2, 32'h0000_0003, "R11 flag set again");
        access(1, 96 + 12, 2, 32'h0000_0077, "R11 no release while odd");
        idle(4);
        chk(rsp_valid == 1'b0, "R10 idle no response", {63'd0, rsp_valid}, 64'd0);
        chk(rsp_q.size() == 0, "R10 all responses seen", 64'(rsp_q.size()), 64'd0);
        chk(rel_q.size() == 0, "R6 all releases seen", 64'(rel_q.size()), 64'd0);
        chk(req_ready == 1'b1, "R10 ready high", {63'd0, req_ready}, 64'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule